// File: doc/BRIEF.md
# Refresh Pulse-Width Mode Detector

This block sits on the memory side of a pseudo-static RAM and turns the refresh control pin into internal refresh events. It watches the active-low refresh request only while the chip is idle, which means the active-low access strobe is high. It measures how long each low pulse lasts. A short pulse triggers one refresh of the row held in an internal counter. A pulse that reaches the self-refresh threshold switches the block into self-refresh. In self-refresh a local timer issues refreshes at a fixed interval until the request pin returns high.

An externally addressed refresh is also supported. On the falling edge of the access strobe, with the row-only qualifier set, the block refreshes the row taken from the upper address bits and ignores the column bits. Each refresh appears as a one-cycle strobe with a row number, plus a flag that tells an external row from a counter row. After any refresh pulse ends, the block holds off new accesses for a fixed recovery time.

Timing limits are given in clock cycles. With the defaults at 125 MHz, self-refresh starts after about 8 us of low time, and the self-refresh interval is one 2048th of 32 ms.

Top module: `rfp_mode_detect`

## Requirements
- R1: After reset, ref_stb and ref_ext are 0, ref_row is 0, self_active is 0 and ready is 1.
- R2: A refresh_n low pulse sampled low on W consecutive rising clock edges with access_n high, where 1 <= W < SELF_MIN_CYC, gives exactly one ref_stb. This strobe appears in the cycle after the edge that samples refresh_n high again, with ref_ext = 0 and ref_row equal to the counter row.
- R3: When refresh_n is sampled low on SELF_MIN_CYC consecutive edges with access_n high, self_active rises after the SELF_MIN_CYC-th edge and stays 1 until the edge that samples refresh_n high.
- R4: In self-refresh, ref_stb fires every REFRESH_PERIOD_CYC cycles. The first strobe comes REFRESH_PERIOD_CYC edges after entry, and strobes stop when refresh_n is released. A low time of H sampled edges therefore yields floor((H - SELF_MIN_CYC) / REFRESH_PERIOD_CYC) strobes.
- R5: The row counter advances by exactly one per internal strobe and wraps from 2^ROW_BITS - 1 to 0. External-row refreshes leave it unchanged.
- R6: refresh_n low while access_n is low is ignored. No strobe fires and self_active stays 0.
- R7: A falling edge of access_n in the idle state with row_only = 1 gives one ref_stb with ref_ext = 1 and ref_row = addr[COL_BITS+ROW_BITS-1:COL_BITS], whatever the column bits addr[COL_BITS-1:0] hold. With row_only = 0, an access gives no strobe.
- R8: After the edge that samples refresh_n high, ready is 0 for RECOVER_CYC cycles, then returns to 1. An access edge in that window gives no strobe.
- R9: ref_stb is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| access_n | input | 1 | Active-low access strobe; high means the chip is idle |
| refresh_n | input | 1 | Active-low refresh request |
| row_only | input | 1 | Marks an access as an external-row refresh |
| addr | input | ROW_BITS+COL_BITS | Address; the upper ROW_BITS bits select the row |
| ref_stb | output | 1 | One-cycle internal refresh strobe |
| ref_row | output | ROW_BITS | Row refreshed by the current strobe |
| ref_ext | output | 1 | Strobe row came from addr rather than the counter |
| self_active | output | 1 | Self-refresh mode is running |
| ready | output | 1 | A new access may start |

## Verification
Pulse widths are swept from one cycle up to one below the self-refresh threshold. This separates the auto-refresh path from the self-refresh path exactly at the boundary. Low times from the threshold up to several timer periods past it separate the entry point from the timer phase, and they pin the strobe count per hold length. Every address is tried as an external-row refresh, which shows that the column bits are dropped and the counter is left alone. Refresh requests made during an access, and accesses made during recovery, show that both are ignored. Enough strobes are issued to wrap the row counter several times.

// File: rtl/rfp_pkg.sv
// Shared types for the refresh pulse-width mode detector.
package rfp_pkg;
    // Control states: idle, measuring a low pulse, self-refresh, recovery hold-off.
    typedef enum logic [1:0] {
        RF_IDLE  = 2'd0,
        RF_LOW   = 2'd1,
        RF_SELF  = 2'd2,
        RF_RECOV = 2'd3
    } rf_state_t;
endpackage

// File: rtl/rfp_mode_fsm.sv
// Measures refresh_n low time while access_n is high and picks the mode.
// A release before SELF_MIN_CYC sampled low edges fires one auto refresh.
// Reaching SELF_MIN_CYC enters self-refresh. Any release starts the recovery
// hold-off of RECOVER_CYC cycles. Assumes inputs are synchronous to clk.
module rfp_mode_fsm
    import rfp_pkg::*;
#(
    parameter int SELF_MIN_CYC = 1000,
    parameter int RECOVER_CYC  = 75
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      access_n,
    input  logic      refresh_n,
    output rf_state_t state,
    output logic      auto_fire
);
    localparam int CNT_W = $clog2(SELF_MIN_CYC + 1);
    localparam int REC_W = $clog2(RECOVER_CYC + 1);

    rf_state_t        state_nx;
    logic [CNT_W-1:0] low_cnt;
    logic [REC_W-1:0] rec_cnt;

    // Next-state and auto-refresh decision.
    always_comb begin
        state_nx  = state;
        auto_fire = 1'b0;
        case (state)
            RF_IDLE:  if (access_n && !refresh_n) state_nx = RF_LOW;
            RF_LOW: begin
                if (refresh_n) begin
                    state_nx  = RF_RECOV;
                    auto_fire = 1'b1;
                end else if (low_cnt == CNT_W'(SELF_MIN_CYC - 1)) begin
                    state_nx = RF_SELF;
                end
            end
            RF_SELF:  if (refresh_n) state_nx = RF_RECOV;
            default:  if (rec_cnt == REC_W'(RECOVER_CYC - 1)) state_nx = RF_IDLE;
        endcase
    end

    // State register and the two width counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RF_IDLE;
            low_cnt <= CNT_W'(1);
            rec_cnt <= '0;
        end else begin
            state   <= state_nx;
            low_cnt <= (state == RF_LOW) ? low_cnt + 1'b1 : CNT_W'(1);
            rec_cnt <= (state == RF_RECOV) ? rec_cnt + 1'b1 : '0;
        end
    end

    AST_LOW_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RF_LOW && $past(state) == RF_IDLE) |-> ($past(access_n) && !$past(refresh_n))); // R6
    AST_SELF_AFTER_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RF_SELF && $past(state) == RF_LOW) |-> ($past(low_cnt) == CNT_W'(SELF_MIN_CYC - 1))); // R3
endmodule

// File: rtl/rfp_interval_timer.sv
// Self-refresh interval timer: while enabled, ticks once per PERIOD_CYC cycles,
// first tick PERIOD_CYC cycles after enable. Assumes PERIOD_CYC >= 2.
module rfp_interval_timer #(
    parameter int PERIOD_CYC = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int T_W = $clog2(PERIOD_CYC);

    logic [T_W-1:0] t_cnt;

    // Tick on the last count of each period.
    always_comb tick = en && (t_cnt == T_W'(PERIOD_CYC - 1));

    // Period counter, cleared whenever disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) t_cnt <= '0;
        else                       t_cnt <= t_cnt + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
endmodule

// File: rtl/rfp_row_counter.sv
// Internal refresh row counter: advances by one per inc and wraps naturally.
module rfp_row_counter #(
    parameter int ROW_BITS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc,
    output logic [ROW_BITS-1:0] row
);
    // Counter update.
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (inc) row <= row + 1'b1;
    end

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(row)); // R5
endmodule

// File: rtl/rfp_mode_detect.sv
// Top of the refresh pulse-width mode detector. It combines the width FSM,
// the self-refresh timer and the row counter. It also detects external-row
// refresh on the access falling edge and registers the strobe outputs.
// Assumes all inputs are synchronous to clk.
module rfp_mode_detect
    import rfp_pkg::*;
#(
    parameter int ROW_BITS           = 11,
    parameter int COL_BITS           = 7,
    parameter int SELF_MIN_CYC       = 1000,
    parameter int REFRESH_PERIOD_CYC = 1953,
    parameter int RECOVER_CYC        = 75,
    localparam int ADDR_W            = ROW_BITS + COL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                access_n,
    input  logic                refresh_n,
    input  logic                row_only,
    input  logic [ADDR_W-1:0]   addr,
    output logic                ref_stb,
    output logic [ROW_BITS-1:0] ref_row,
    output logic                ref_ext,
    output logic                self_active,
    output logic                ready
);
    rf_state_t           state;
    logic                auto_fire, tick, int_fire, ext_fire, acc_q;
    logic [ROW_BITS-1:0] ctr_row;

    rfp_mode_fsm #(.SELF_MIN_CYC(SELF_MIN_CYC), .RECOVER_CYC(RECOVER_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .access_n(access_n), .refresh_n(refresh_n),
        .state(state), .auto_fire(auto_fire));

    rfp_interval_timer #(.PERIOD_CYC(REFRESH_PERIOD_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(state == RF_SELF && !refresh_n), .tick(tick));

    rfp_row_counter #(.ROW_BITS(ROW_BITS)) u_rows (
        .clk(clk), .rst_n(rst_n), .inc(int_fire), .row(ctr_row));

    // Refresh sources: counter-based (auto or timer) and external-row.
    always_comb begin
        int_fire = auto_fire | tick;
        ext_fire = (state == RF_IDLE) && acc_q && !access_n && row_only;
    end

    // Access-strobe history for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= 1'b1;
        else        acc_q <= access_n;
    end

    // Registered strobe, row and source flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_stb <= 1'b0;
            ref_ext <= 1'b0;
            ref_row <= '0;
        end else begin
            ref_stb <= int_fire | ext_fire;
            ref_ext <= ext_fire;
            if (ext_fire)      ref_row <= addr[ADDR_W-1:COL_BITS];
            else if (int_fire) ref_row <= ctr_row;
        end
    end

    // Mode and access-permission flags.
    always_comb begin
        self_active = (state == RF_SELF);
        ready       = (state == RF_IDLE);
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |=> !ref_stb); // R9
    AST_EXT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_stb && ref_ext) |-> (ref_row == ROW_BITS'($past(addr) >> COL_BITS))); // R7
    AST_EXT_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_stb && ref_ext) |-> $stable(ctr_row)); // R5
endmodule

// File: tb/test_rfp_mode_detect.sv
module test_rfp_mode_detect;
    localparam int RB = 4, CB = 3, SMIN = 10, PER = 4, REC = 3;
    localparam int AW = RB + CB;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          access_n = 1'b1, refresh_n = 1'b1, row_only = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ref_stb, ref_ext, self_active, ready;
    logic [RB-1:0] ref_row;

    int n_chk = 0, n_bad = 0, exp_row = 0;

    always #4 clk = ~clk;

    rfp_mode_detect #(.ROW_BITS(RB), .COL_BITS(CB), .SELF_MIN_CYC(SMIN),
        .REFRESH_PERIOD_CYC(PER), .RECOVER_CYC(REC)) i_rfp_mode_detect (
        .clk(clk), .rst_n(rst_n), .access_n(access_n), .refresh_n(refresh_n),
        .row_only(row_only), .addr(addr), .ref_stb(ref_stb), .ref_row(ref_row),
        .ref_ext(ref_ext), .self_active(self_active), .ready(ready));

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Called at the negedge right after the release edge: ready low REC cycles (R8).
    task automatic recovery;
        for (int i = 0; i < REC; i++) begin
            if (i > 0) @(negedge clk);
            check("R8 ready low", int'(ready), 0);
        end
        @(negedge clk);
        check("R8 ready back", int'(ready), 1);
        check("R9 no strobe", int'(ref_stb), 0);
    endtask

    task automatic auto_pulse(input int w);
        refresh_n = 1'b0;
        repeat (w) @(negedge clk);
        refresh_n = 1'b1;
        @(negedge clk);
        check("R2 strobe", int'(ref_stb), 1);
        check("R2 ext flag", int'(ref_ext), 0);
        check("R2 row", int'(ref_row), exp_row);
        exp_row = (exp_row + 1) % (1 << RB);
        recovery();
    endtask

    task automatic self_hold(input int h);
        int n = 0;
        refresh_n = 1'b0;
        for (int i = 1; i <= h; i++) begin
            @(negedge clk);
            if (i == SMIN - 1) check("R3 not yet self", int'(self_active), 0);
            if (i >= SMIN) check("R3 self active", int'(self_active), 1);
            if (ref_stb) begin
                check("R5 self row", int'(ref_row), exp_row);
                exp_row = (exp_row + 1) % (1 << RB);
                n++;
            end
        end
        refresh_n = 1'b1;
        @(negedge clk);
        check("R4 stop strobe", int'(ref_stb), 0);
        check("R3 self left", int'(self_active), 0);
        check("R4 strobe count", n, (h - SMIN) / PER);
        recovery();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stb", int'(ref_stb), 0);
        check("R1 ext", int'(ref_ext), 0);
        check("R1 row", int'(ref_row), 0);
        check("R1 self", int'(self_active), 0);
        check("R1 ready", int'(ready), 1);

        // R2: widths below the threshold, swept twice.
        for (int k = 0; k < 2; k++)
            for (int w = 1; w < SMIN; w++) auto_pulse(w);

        // R3/R4/R5: self-refresh holds of many lengths (wraps the counter).
        for (int h = SMIN; h <= SMIN + 5 * PER + 1; h++) self_hold(h);

        // R7: every address as an external-row refresh.
        for (int a = 0; a < (1 << AW); a++) begin
            addr = AW'(a); row_only = 1'b1; access_n = 1'b0;
            @(negedge clk);
            check("R7 strobe", int'(ref_stb), 1);
            check("R7 ext flag", int'(ref_ext), 1);
            check("R7 row", int'(ref_row), a >> CB);
            access_n = 1'b1; row_only = 1'b0;
            @(negedge clk);
            check("R9 single", int'(ref_stb), 0);
        end
        auto_pulse(2);  // R5: counter untouched by external refreshes

        // R7: plain access without row_only gives nothing.
        access_n = 1'b0;
        repeat (3) begin @(negedge clk); check("R7 plain access", int'(ref_stb), 0); end

        // R6: refresh request during an access is ignored.
        refresh_n = 1'b0;
        repeat (2 * SMIN) begin
            @(negedge clk);
            check("R6 no strobe", int'(ref_stb), 0);
            check("R6 no self", int'(self_active), 0);
        end
        refresh_n = 1'b1;
        @(negedge clk);
        access_n = 1'b1;
        repeat (3) begin @(negedge clk); check("R6 after", int'(ref_stb) + 2 * int'(!ready), 0); end
        auto_pulse(3);

        // R8: access edge during recovery is ignored.
        refresh_n = 1'b0;
        repeat (2) @(negedge clk);
        refresh_n = 1'b1;
        @(negedge clk);
        check("R2 strobe pre-recov", int'(ref_stb), 1);
        exp_row = (exp_row + 1) % (1 << RB);
        row_only = 1'b1; access_n = 1'b0;
        repeat (REC + 2) begin @(negedge clk); check("R8 access ignored", int'(ref_stb), 0); end
        access_n = 1'b1; row_only = 1'b0;
        @(negedge clk);
        auto_pulse(1);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end
endmodule